// File: doc/BRIEF.md
# Single-Cycle Reduced RV32I Core

This block is a small processor core that completes one instruction on every clock edge. At the start of each cycle it presents its program counter, and it receives the four instruction bytes found at that address and the next three addresses. It joins the bytes into one 32-bit instruction word. It then decodes the fixed fields and builds the sign-extended immediate that the instruction format calls for. Next it reads two operands from a 32-entry register file and computes the result in one ALU. At the clock edge it writes the result back and moves to the next program counter.

The core supports these instructions:
- register-register ALU operations;
- register-immediate ALU operations;
- word loads and word stores, through a combinational word-wide data port;
- four unsigned or equality conditional branches;
- a PC-relative jump that saves the link address.

An opcode outside this set retires as an empty slot: it only advances the program counter. The core is meant as a compact control engine next to byte-addressed program storage and a word data RAM.

Top module: `rvmini_core`

## Requirements
- R1: The instruction word is built from fetch_bytes, where lane k (bits 8k+7:8k) carries the byte at address fetch_pc+k. Lane 0 becomes instruction bits 7:0 and lane 3 becomes bits 31:24. The fields are: opcode bits 6:0, rd 11:7, funct3 14:12, rs1 19:15, rs2 24:20, upper field 31:25.
- R2: A synchronous active-high rst loads the program counter with 0 at the next edge. While rst is high, dmem_we stays low and no register is written.
- R3: An instruction that neither jumps nor takes a branch leaves the next program counter equal to the current one plus 4.
- R4: Opcode 0110011 selects a register-register operation on {bit 30, funct3}:
  - 000 adds, or subtracts when bit 30 is 1;
  - 010 is a signed less-than and 011 an unsigned less-than, each writing 1 or 0;
  - 100 is XOR, 110 is OR and 111 is AND.
- R5: Shifts use funct3 001 (left) and 101 (right), and they use only the low 5 bits of the shift operand. A right shift fills vacated bits with zeros when bit 30 is 0, and with the operand's sign bit when bit 30 is 1.
- R6: Opcode 0010011 applies the same operations with the sign-extended 12-bit immediate (bits 31:20) as the second operand. Bit 30 never turns an add into a subtract, but it still selects the arithmetic right shift.
- R7: Opcode 1100011 compares rs1 with rs2 according to funct3: 000 for equal, 001 for not equal, 110 for unsigned less-than, 111 for unsigned greater-or-equal. A taken branch moves the PC to PC plus the 13-bit branch immediate, which has bit 0 at zero and is sign-extended.
- R8: Opcode 1101111 writes PC+4 to rd and moves the PC to PC plus the 21-bit jump immediate, which has bit 0 at zero and is sign-extended.
- R9: Opcode 0000011 loads rd from dmem_rdata. Opcode 0100011 drives dmem_we with dmem_wdata equal to rs2. Both instructions use the address rs1 plus the sign-extended 12-bit offset; for the store, that offset is taken from bits 31:25 and 11:7.
- R10: Register 0 always reads as zero, and writes to it are dropped.
- R11: A branch or a store never writes the register file, whatever its bits 11:7 hold.
- R12: Any other opcode changes no register, performs no store, and only advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | output | 32 | Byte address of the current instruction |
| fetch_bytes | input | 32 | Four instruction bytes; lane k holds the byte at fetch_pc+k |
| dmem_addr | output | 32 | Data byte address (rs1 plus offset) |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe for the current cycle |
| dmem_rdata | input | 32 | Load data, valid in the same cycle as dmem_addr |

## Verification
The assertions assume that the program storage and the data RAM answer within the same cycle. They also assume that fetch_bytes and dmem_rdata are settled and free of unknowns before each rising edge. The bench models both memories combinationally from arrays, indexed by fetch_pc and dmem_addr. It drives rst only at falling edges, and it uses only word-aligned data addresses, so the combinational data path never sees a half-updated input.

// File: rtl/rvmini_pkg.sv
`timescale 1ns/1ps
package rvmini_pkg;
  localparam int XLEN   = 32;
  localparam int ILEN   = 32;
  localparam int BYTE_W = 8;
  localparam int SHW    = $clog2(XLEN);

  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'b0000,
    ALU_SUB  = 4'b1000,
    ALU_SLL  = 4'b0001,
    ALU_SLT  = 4'b0010,
    ALU_SLTU = 4'b0011,
    ALU_XOR  = 4'b0100,
    ALU_SRL  = 4'b0101,
    ALU_SRA  = 4'b1101,
    ALU_OR   = 4'b0110,
    ALU_AND  = 4'b0111
  } alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    use_imm;
    logic    is_branch;
    logic    is_jal;
    logic    is_load;
    logic    is_store;
    alu_op_e op;
  } ctrl_t;
endpackage

// File: rtl/rvmini_decode.sv
`timescale 1ns/1ps
module rvmini_decode
  import rvmini_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output ctrl_t           ctrl,
  output logic [4:0]      rd,
  output logic [4:0]      rs1,
  output logic [4:0]      rs2,
  output logic [2:0]      funct3,
  output logic [XLEN-1:0] imm
);
  logic [6:0] opc;
  logic       alt;

  assign opc    = instr[6:0];
  assign rd     = instr[11:7];
  assign funct3 = instr[14:12];
  assign rs1    = instr[19:15];
  assign rs2    = instr[24:20];
  assign alt    = instr[30];

  always_comb begin
    ctrl    = '0;
    ctrl.op = ALU_ADD;
    imm     = '0;
    unique case (opc)
      OPC_REG: begin
        ctrl.rf_we = 1'b1;
        ctrl.op    = (funct3 == 3'b000 || funct3 == 3'b101) ?
                     alu_op_e'({alt, funct3}) : alu_op_e'({1'b0, funct3});
      end
      OPC_IMM: begin
        ctrl.rf_we   = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.op      = (funct3 == 3'b101) ?
                       alu_op_e'({alt, funct3}) : alu_op_e'({1'b0, funct3});
        imm          = {{(XLEN-12){instr[31]}}, instr[31:20]};
      end
      OPC_LOAD: begin
        ctrl.rf_we   = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.is_load = 1'b1;
        imm          = {{(XLEN-12){instr[31]}}, instr[31:20]};
      end
      OPC_STORE: begin
        ctrl.use_imm  = 1'b1;
        ctrl.is_store = 1'b1;
        imm           = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
      end
      OPC_BRANCH: begin
        ctrl.is_branch = 1'b1;
        imm = {{(XLEN-13){instr[31]}}, instr[31], instr[7],
               instr[30:25], instr[11:8], 1'b0};
      end
      OPC_JAL: begin
        ctrl.rf_we  = 1'b1;
        ctrl.is_jal = 1'b1;
        imm = {{(XLEN-21){instr[31]}}, instr[31], instr[19:12],
               instr[20], instr[30:21], 1'b0};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rvmini_alu.sv
`timescale 1ns/1ps
module rvmini_alu
  import rvmini_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  logic [SHW-1:0] shamt;
  assign shamt = b[SHW-1:0];

  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_SLL:  y = a << shamt;
      ALU_SLT:  y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_SLTU: y = {{(XLEN-1){1'b0}}, a < b};
      ALU_XOR:  y = a ^ b;
      ALU_SRL:  y = a >> shamt;
      ALU_SRA:  y = $unsigned($signed(a) >>> shamt);
      ALU_OR:   y = a | b;
      ALU_AND:  y = a & b;
      default:  y = a + b;
    endcase
  end
endmodule

// File: rtl/rvmini_regfile.sv
`timescale 1ns/1ps
module rvmini_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb
);
  logic [W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != '0) mem[wa] <= wd;
  end

  assign qa = (ra == '0) ? '0 : mem[ra];
  assign qb = (rb == '0) ? '0 : mem[rb];
endmodule

// File: rtl/rvmini_core.sv
`timescale 1ns/1ps
module rvmini_core
  import rvmini_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter int          NREG     = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  output logic [XLEN-1:0]        fetch_pc,
  input  logic [ILEN-1:0]        fetch_bytes,
  output logic [XLEN-1:0]        dmem_addr,
  output logic [XLEN-1:0]        dmem_wdata,
  output logic                   dmem_we,
  input  logic [XLEN-1:0]        dmem_rdata
);
  localparam int LANES = ILEN / BYTE_W;
  localparam int RAW   = $clog2(NREG);

  logic [XLEN-1:0] pc_q, pc_seq, pc_tgt, pc_next;
  logic [ILEN-1:0] instr;
  ctrl_t           ctrl;
  logic [4:0]      rd, rs1, rs2;
  logic [2:0]      funct3;
  logic [XLEN-1:0] imm, rs1_val, rs2_val, alu_b, alu_y, wb_val;
  logic            br_take, redirect, rf_we;

  // byte lanes, lowest address in the lowest bits
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign instr[k*BYTE_W +: BYTE_W] = fetch_bytes[k*BYTE_W +: BYTE_W];
  end

  rvmini_decode u_dec (
    .instr(instr), .ctrl(ctrl), .rd(rd), .rs1(rs1), .rs2(rs2),
    .funct3(funct3), .imm(imm)
  );

  rvmini_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk(clk), .we(rf_we), .wa(rd[RAW-1:0]), .wd(wb_val),
    .ra(rs1[RAW-1:0]), .rb(rs2[RAW-1:0]), .qa(rs1_val), .qb(rs2_val)
  );

  assign alu_b = ctrl.use_imm ? imm : rs2_val;

  rvmini_alu u_alu (.op(ctrl.op), .a(rs1_val), .b(alu_b), .y(alu_y));

  always_comb begin
    unique case (funct3)
      3'b000:  br_take = (rs1_val == rs2_val);
      3'b001:  br_take = (rs1_val != rs2_val);
      3'b110:  br_take = (rs1_val <  rs2_val);
      3'b111:  br_take = (rs1_val >= rs2_val);
      default: br_take = 1'b0;
    endcase
  end

  assign redirect = ctrl.is_jal || (ctrl.is_branch && br_take);
  assign pc_seq   = pc_q + XLEN'(4);
  assign pc_tgt   = pc_q + imm;
  assign pc_next  = redirect ? pc_tgt : pc_seq;

  assign wb_val = ctrl.is_jal  ? pc_seq :
                  ctrl.is_load ? dmem_rdata : alu_y;
  assign rf_we  = ctrl.rf_we && !rst;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_next;
  end

  assign fetch_pc   = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rs2_val;
  assign dmem_we    = ctrl.is_store && !rst;

  // R2
  pc_reset_chk: assert property (@(posedge clk) rst |=> pc_q == RESET_PC);

  // R3
  pc_seq_chk: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> pc_q == $past(pc_q) + XLEN'(4));

  // R7
  pc_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |=> pc_q == $past(pc_q) + $past(imm));

  // R11
  no_ctl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.is_store || ctrl.is_branch) |-> !rf_we);

  // R9
  store_excl_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !rf_we);

  // R5
  sra_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.op == ALU_SRA) |-> alu_y[XLEN-1] == rs1_val[XLEN-1]);

  // R4
  cmp_bool_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.op == ALU_SLT || ctrl.op == ALU_SLTU) |-> alu_y[XLEN-1:1] == '0);
endmodule

// File: tb/tb_rvmini_core.sv
`timescale 1ns/1ps
module tb_rvmini_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_pc, fetch_bytes, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [7:0]  imem [256];
  logic [31:0] dmem [64];
  int total = 0, bad = 0, wp = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rvmini_core dut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .fetch_bytes(fetch_bytes),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  always_comb begin
    fetch_bytes = {imem[fetch_pc[7:0] + 8'd3], imem[fetch_pc[7:0] + 8'd2],
                   imem[fetch_pc[7:0] + 8'd1], imem[fetch_pc[7:0]]};
    dmem_rdata  = dmem[dmem_addr[7:2]];
  end

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] e_r(input logic [6:0] f7, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] e_i(input logic [11:0] im, input logic [4:0] rs1,
      input logic [2:0] f3, input logic [4:0] rd);
    return {im, rs1, f3, rd, 7'b0010011};
  endfunction
  function automatic logic [31:0] e_lw(input logic [11:0] im, input logic [4:0] rs1,
      input logic [4:0] rd);
    return {im, rs1, 3'b010, rd, 7'b0000011};
  endfunction
  function automatic logic [31:0] e_sw(input logic [11:0] im, input logic [4:0] rs2,
      input logic [4:0] rs1);
    return {im[11:5], rs2, rs1, 3'b010, im[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_b(input logic [12:0] im, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3);
    return {im[12], im[10:5], rs2, rs1, f3, im[4:1], im[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_j(input logic [20:0] im, input logic [4:0] rd);
    return {im[20], im[10:1], im[11], im[19:12], rd, 7'b1101111};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) imem[i] = 8'h00;
    for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
    wp = 0;
  endtask

  task automatic emit(input logic [31:0] w);
    for (int k = 0; k < 4; k++) imem[wp*4 + k] = w[k*8 +: 8];
    wp++;
  endtask

  task automatic run(input int n);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_init();
    @(posedge clk); @(negedge clk);
    chk("R2 pc after reset", fetch_pc, 32'h0);
    chk("R2 no store in reset", {31'b0, dmem_we}, 32'h0);
  endtask

  task automatic t_alu_reg();
    clear_mem();
    emit(e_i(12'hFFB, 0, 3'b000, 1));
    emit(e_i(12'h003, 0, 3'b000, 2));
    emit(e_r(7'h00, 2, 1, 3'b000, 3));  emit(e_sw(12'd0, 3, 0));
    emit(e_r(7'h20, 2, 1, 3'b000, 4));  emit(e_sw(12'd4, 4, 0));
    emit(e_r(7'h00, 2, 1, 3'b010, 5));  emit(e_sw(12'd8, 5, 0));
    emit(e_r(7'h00, 2, 1, 3'b011, 6));  emit(e_sw(12'd12, 6, 0));
    emit(e_r(7'h00, 2, 1, 3'b100, 7));  emit(e_sw(12'd16, 7, 0));
    emit(e_r(7'h00, 2, 1, 3'b110, 8));  emit(e_sw(12'd20, 8, 0));
    emit(e_r(7'h00, 2, 1, 3'b111, 9));  emit(e_sw(12'd24, 9, 0));
    emit(e_i(12'd35, 0, 3'b000, 10));
    emit(e_r(7'h00, 10, 1, 3'b001, 11)); emit(e_sw(12'd28, 11, 0));
    emit(e_r(7'h00, 10, 1, 3'b101, 12)); emit(e_sw(12'd32, 12, 0));
    emit(e_r(7'h20, 10, 1, 3'b101, 13)); emit(e_sw(12'd36, 13, 0));
    emit(e_r(7'h00, 1, 2, 3'b011, 14));  emit(e_sw(12'd40, 14, 0));
    emit(e_j(21'd0, 0));
    run(40);
    // R1: every result depends on correct byte-lane assembly
    chk("R1 R4 add", dmem[0], 32'hFFFFFFFE);
    chk("R4 sub", dmem[1], 32'hFFFFFFF8);
    chk("R4 slt signed", dmem[2], 32'h1);
    chk("R4 sltu", dmem[3], 32'h0);
    chk("R4 xor", dmem[4], 32'hFFFFFFF8);
    chk("R4 or", dmem[5], 32'hFFFFFFFB);
    chk("R4 and", dmem[6], 32'h3);
    chk("R5 sll low5", dmem[7], 32'hFFFFFFD8);
    chk("R5 srl", dmem[8], 32'h1FFFFFFF);
    chk("R5 sra", dmem[9], 32'hFFFFFFFF);
    chk("R4 sltu true", dmem[10], 32'h1);
  endtask

  task automatic t_alu_imm();
    clear_mem();
    emit(e_i(12'h7FF, 0, 3'b000, 2));  emit(e_sw(12'd0, 2, 0));
    emit(e_i(12'h800, 0, 3'b000, 3));  emit(e_sw(12'd4, 3, 0));
    emit(e_i(12'h400, 0, 3'b000, 4));  emit(e_sw(12'd8, 4, 0));
    emit(e_i(12'hFFF, 3, 3'b010, 5));  emit(e_sw(12'd12, 5, 0));
    emit(e_i(12'hFFF, 2, 3'b011, 6));  emit(e_sw(12'd16, 6, 0));
    emit(e_i(12'hFFF, 2, 3'b100, 7));  emit(e_sw(12'd20, 7, 0));
    emit(e_i(12'h800, 2, 3'b110, 8));  emit(e_sw(12'd24, 8, 0));
    emit(e_i(12'h7FF, 3, 3'b111, 9));  emit(e_sw(12'd28, 9, 0));
    emit(e_i(12'h404, 3, 3'b101, 10)); emit(e_sw(12'd32, 10, 0));
    emit(e_i(12'h004, 3, 3'b101, 11)); emit(e_sw(12'd36, 11, 0));
    emit(e_i(12'h014, 2, 3'b001, 12)); emit(e_sw(12'd40, 12, 0));
    emit(e_i(12'h03F, 2, 3'b001, 13)); emit(e_sw(12'd44, 13, 0));
    emit(e_i(12'hFFF, 2, 3'b010, 14)); emit(e_sw(12'd48, 14, 0));
    emit(e_j(21'd0, 0));
    run(40);
    chk("R6 addi max", dmem[0], 32'h000007FF);
    chk("R6 addi sign ext", dmem[1], 32'hFFFFF800);
    chk("R6 no sub with bit30", dmem[2], 32'h00000400);
    chk("R6 slti", dmem[3], 32'h1);
    chk("R6 sltiu", dmem[4], 32'h1);
    chk("R6 xori", dmem[5], 32'hFFFFF800);
    chk("R6 ori", dmem[6], 32'hFFFFFFFF);
    chk("R6 andi", dmem[7], 32'h0);
    chk("R6 srai", dmem[8], 32'hFFFFFF80);
    chk("R5 srli zero fill", dmem[9], 32'h0FFFFF80);
    chk("R6 slli", dmem[10], 32'h7FF00000);
    chk("R5 slli low5 only", dmem[11], 32'h80000000);
    chk("R6 slti false", dmem[12], 32'h0);
  endtask

  task automatic t_branch();
    logic [2:0] f3 [10];
    logic [4:0] ra [10];
    logic [4:0] rb [10];
    f3 = '{3'b000, 3'b000, 3'b001, 3'b001, 3'b110, 3'b110, 3'b111, 3'b111, 3'b111, 3'b110};
    ra = '{5'd1, 5'd1, 5'd1, 5'd1, 5'd1, 5'd2, 5'd2, 5'd1, 5'd1, 5'd3};
    rb = '{5'd1, 5'd2, 5'd2, 5'd1, 5'd2, 5'd1, 5'd1, 5'd1, 5'd2, 5'd1};
    clear_mem();
    emit(e_i(12'd5, 0, 3'b000, 1));
    emit(e_i(12'd7, 0, 3'b000, 2));
    emit(e_i(12'hFFF, 0, 3'b000, 3));
    emit(e_i(12'd0, 0, 3'b000, 20));
    for (int k = 0; k < 10; k++) begin
      emit(e_b(13'd8, rb[k], ra[k], f3[k]));
      emit(e_i(12'(1 << k), 20, 3'b110, 20));
    end
    emit(e_i(12'd0, 0, 3'b000, 21));
    emit(e_i(12'd3, 0, 3'b000, 22));
    emit(e_i(12'd1, 21, 3'b000, 21));
    emit(e_b(13'h1FFC, 22, 21, 3'b001));
    emit(e_sw(12'd0, 20, 0));
    emit(e_sw(12'd4, 21, 0));
    emit(e_j(21'd0, 0));
    run(60);
    chk("R7 branch outcome mask", dmem[0], 32'h0000032A);
    chk("R7 backward branch loop", dmem[1], 32'h3);
    chk("R7 pc at halt", fetch_pc, 32'd120);
  endtask

  task automatic t_jal();
    clear_mem();
    emit(e_i(12'd0, 0, 3'b000, 6));
    emit(e_j(21'd12, 5));
    emit(e_i(12'd1, 0, 3'b000, 6));
    emit(e_i(12'd2, 0, 3'b000, 6));
    emit(e_sw(12'd0, 5, 0));
    emit(e_sw(12'd4, 6, 0));
    emit(e_j(21'd8, 0));
    emit(e_i(12'd3, 0, 3'b000, 6));
    emit(e_sw(12'd8, 6, 0));
    emit(e_j(21'd0, 0));
    run(20);
    chk("R8 link value", dmem[0], 32'd8);
    chk("R8 skipped instructions", dmem[1], 32'h0);
    chk("R8 jump to x0 skips", dmem[2], 32'h0);
    chk("R8 pc at halt", fetch_pc, 32'd36);
  endtask

  task automatic t_mem();
    clear_mem();
    dmem[25] = 32'hCAFEF00D;
    emit(e_i(12'd64, 0, 3'b000, 1));
    emit(e_i(12'h123, 0, 3'b000, 2));
    emit(e_sw(12'hFF8, 2, 1));
    emit(e_lw(12'hFF8, 1, 3));
    emit(e_i(12'd1, 3, 3'b000, 3));
    emit(e_sw(12'd12, 3, 1));
    emit(e_lw(12'd36, 1, 4));
    emit(e_sw(12'd40, 4, 1));
    emit(e_j(21'd0, 0));
    run(20);
    chk("R9 store negative offset", dmem[14], 32'h123);
    chk("R9 load then store", dmem[19], 32'h124);
    chk("R9 preload load split store", dmem[26], 32'hCAFEF00D);
  endtask

  task automatic t_nowrite();
    clear_mem();
    dmem[0] = 32'hFFFFFFFF;
    dmem[2] = 32'hFFFFFFFF;
    emit(e_i(12'h037, 0, 3'b000, 0));
    emit(e_sw(12'd0, 0, 0));
    emit(e_i(12'd9, 0, 3'b000, 7));
    emit(e_i(12'd1, 0, 3'b000, 8));
    emit(e_sw(12'd7, 0, 8));
    emit(e_sw(12'd12, 7, 0));
    emit(e_b(13'h0806, 7, 0, 3'b000));
    emit(e_sw(12'd16, 7, 0));
    emit({20'hABCDE, 5'd7, 7'b1111111});
    emit({20'h12345, 5'd7, 7'b0110111});
    emit(e_sw(12'd20, 7, 0));
    emit(e_j(21'd0, 0));
    run(20);
    chk("R10 x0 reads zero", dmem[0], 32'h0);
    chk("R10 x0 store data", dmem[2], 32'h0);
    chk("R11 store keeps rd", dmem[3], 32'd9);
    chk("R11 branch keeps rd", dmem[4], 32'd9);
    chk("R12 unknown opcode no write", dmem[5], 32'd9);
    chk("R12 pc advanced past", fetch_pc, 32'd44);
  endtask

  task automatic t_reset_mid();
    clear_mem();
    emit(e_sw(12'd0, 9, 0));
    emit(e_i(12'd1, 9, 3'b000, 9));
    emit(e_j(21'h1FFFF8, 0));
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 pc held", fetch_pc, 32'h0);
    chk("R2 store blocked", {31'b0, dmem_we}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R2 store still blocked", {31'b0, dmem_we}, 32'h0);
    rst = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R3 loop pc", fetch_pc, 32'd4);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 midrun reset", fetch_pc, 32'h0);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_mem();
    t_reset_init();
    t_alu_reg();
    t_alu_imm();
    t_branch();
    t_jal();
    t_mem();
    t_nowrite();
    t_reset_mid();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule